// File: doc/BRIEF.md
# Serial Identification Memory with Self-Maintained Checksums

This block is a 128-byte identification store for a pluggable module. A host reads it over a two-wire serial bus, and the host can also write it over that bus. The block answers only at device byte 0xA0 for writes and 0xA1 for reads. A host first sends a word address to set an internal byte pointer. It then either writes data bytes, or issues a repeated start and reads. Each read streams bytes from the pointer onward, MSB first. A parallel configuration port loads the image one byte per clock at configuration time.

Two bytes of the image are not stored. The block derives them. Byte 63 always reads as the 8-bit sum of bytes 0 to 62, and byte 95 always reads as the 8-bit sum of bytes 64 to 94. A write to a covered byte updates the matching running sum in the same clock, so a host never sees a stale checksum. The bus pins are oversampled by the system clock. The data line is open-drain and is modelled as a pull-low enable.

Top module: `serial_id_mem`

## Requirements
- R1: After reset, bytes 0, 1, 6, 11, 12 and 18 read as 0x03, 0x04, 0x08, 0x01, 0x0D and 0x64. Every other stored byte reads 0x00, byte 63 reads 0x81 and byte 95 reads 0x00. The data line is released.
- R2: The block acknowledges a device byte only when its upper seven bits are 1010000. After any other device byte it leaves the data line released until the next START.
- R3: A write header followed by a word address sets the byte pointer to the low 7 bits of that address; the MSB is ignored. A repeated start with device byte 0xA1 then returns the byte at the pointer, MSB first.
- R4: During a sequential read the pointer advances by one after each byte. It wraps from 127 to 0.
- R5: When the master answers a read byte with NACK, the read ends. The block does not drive the data line again until a new START.
- R6: Each data byte written over the bus is acknowledged and stored at the pointer. The pointer then advances by one and wraps from 127 to 0.
- R7: A configuration-port write stores its byte in one clock. That byte is visible to the next bus read.
- R8: Byte 63 always reads as the low 8 bits of the sum of bytes 0 to 62, after any write from either port.
- R9: Byte 95 always reads as the low 8 bits of the sum of bytes 64 to 94. Writes to bytes 96 to 127 change neither checksum.
- R10: Writes to byte 63 or byte 95 from either port are ignored. Over the bus they are still acknowledged and still advance the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls the serial data line low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The bench checks the boundaries of the two checksum windows: bytes 62/63/64 and 94/95/96. An off-by-one range would show up as a checksum byte that moves when a neighbour outside its window is written, or one that misses a change from inside. Writes that land on 63 and 95 are aimed at a design that stores them, which would read back host data instead of the sum. Bus writes and reads run across the 127-to-0 edge, where a pointer that fails to wrap would return or overwrite the wrong byte. The bench also covers a word address with its MSB set, a foreign device address that a careless decoder might acknowledge, and a NACK after which a block that keeps streaming would pull the line low during the master's extra clocks.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int unsigned MEM_BYTES = 128;
    localparam int unsigned PTR_W     = $clog2(MEM_BYTES);

    typedef logic [7:0]       byte_t;
    typedef logic [PTR_W-1:0] ptr_t;

    // Derived checksum positions and the first byte of the upper window.
    localparam ptr_t CK_LO_POS   = ptr_t'(63);
    localparam ptr_t HI_FIRST    = ptr_t'(64);
    localparam ptr_t CK_HI_POS   = ptr_t'(95);

    typedef enum logic [3:0] {
        BUS_IDLE,
        BUS_DEV,
        BUS_DEV_ACK,
        BUS_WADDR,
        BUS_WADDR_ACK,
        BUS_WDATA,
        BUS_WDATA_ACK,
        BUS_RDATA,
        BUS_RACK
    } bus_state_e;

    // Power-on contents of the identification image.
    function automatic byte_t image_byte(input int unsigned idx);
        case (idx)
            0:       return 8'h03;
            1:       return 8'h04;
            6:       return 8'h08;
            11:      return 8'h01;
            12:      return 8'h0D;
            18:      return 8'h64;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t image_sum(input int unsigned first, input int unsigned last);
        byte_t acc;
        acc = 8'h00;
        for (int unsigned i = first; i <= last; i++) begin
            acc = acc + image_byte(i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/sid_edge_sync.sv
module sid_edge_sync
    import sid_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_sh[STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_now   = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_now & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_now & sync_q.scl_prev;
    assign start_det = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

    // START and STOP are mutually exclusive, and neither coincides with a clock edge.
    p_framing_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall}));

endmodule

// File: rtl/sid_bus_fsm.sv
module sid_bus_fsm
    import sid_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sda_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_det,
    input  logic  stop_det,
    input  byte_t rd_data,
    output ptr_t  ptr,
    output logic  wr_en,
    output ptr_t  wr_addr,
    output byte_t wr_data,
    output logic  sda_oe
);

    typedef struct packed {
        bus_state_e state;
        logic [3:0] cnt;
        byte_t      shreg;
        logic       rw;
        logic       got;
        ptr_t       ptr;
        logic       oe;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d   = fsm_q;
        wr_en   = 1'b0;
        wr_addr = fsm_q.ptr;
        wr_data = fsm_q.shreg;

        if (start_det) begin
            fsm_d.state = BUS_DEV;
            fsm_d.cnt   = 4'd0;
            fsm_d.got   = 1'b0;
            fsm_d.oe    = 1'b0;
        end else if (stop_det) begin
            fsm_d.state = BUS_IDLE;
            fsm_d.got   = 1'b0;
            fsm_d.oe    = 1'b0;
        end else begin
            unique case (fsm_q.state)
                BUS_DEV, BUS_WADDR, BUS_WDATA: begin
                    if (scl_rise && !fsm_q.got) begin
                        fsm_d.shreg = {fsm_q.shreg[6:0], sda_s};
                        fsm_d.cnt   = fsm_q.cnt + 4'd1;
                        if (fsm_q.cnt == 4'd7) begin
                            fsm_d.got = 1'b1;
                        end
                    end else if (scl_fall && fsm_q.got) begin
                        fsm_d.got = 1'b0;
                        fsm_d.cnt = 4'd0;
                        if (fsm_q.state == BUS_DEV) begin
                            if (fsm_q.shreg[7:1] == DEV_ADDR) begin
                                fsm_d.rw    = fsm_q.shreg[0];
                                fsm_d.oe    = 1'b1;
                                fsm_d.state = BUS_DEV_ACK;
                            end else begin
                                fsm_d.state = BUS_IDLE;
                            end
                        end else if (fsm_q.state == BUS_WADDR) begin
                            fsm_d.ptr   = fsm_q.shreg[PTR_W-1:0];
                            fsm_d.oe    = 1'b1;
                            fsm_d.state = BUS_WADDR_ACK;
                        end else begin
                            wr_en       = 1'b1;
                            fsm_d.ptr   = fsm_q.ptr + ptr_t'(1);
                            fsm_d.oe    = 1'b1;
                            fsm_d.state = BUS_WDATA_ACK;
                        end
                    end
                end
                BUS_DEV_ACK: begin
                    if (scl_fall) begin
                        if (fsm_q.rw) begin
                            fsm_d.shreg = rd_data;
                            fsm_d.oe    = ~rd_data[7];
                            fsm_d.state = BUS_RDATA;
                        end else begin
                            fsm_d.oe    = 1'b0;
                            fsm_d.state = BUS_WADDR;
                        end
                    end
                end
                BUS_WADDR_ACK, BUS_WDATA_ACK: begin
                    if (scl_fall) begin
                        fsm_d.oe    = 1'b0;
                        fsm_d.state = BUS_WDATA;
                    end
                end
                BUS_RDATA: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == 4'd7) begin
                            fsm_d.oe    = 1'b0;
                            fsm_d.cnt   = 4'd0;
                            fsm_d.ptr   = fsm_q.ptr + ptr_t'(1);
                            fsm_d.state = BUS_RACK;
                        end else begin
                            fsm_d.shreg = {fsm_q.shreg[6:0], 1'b0};
                            fsm_d.oe    = ~fsm_q.shreg[6];
                            fsm_d.cnt   = fsm_q.cnt + 4'd1;
                        end
                    end
                end
                BUS_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            fsm_d.state = BUS_IDLE;
                        end else begin
                            fsm_d.got = 1'b1;
                        end
                    end else if (scl_fall && fsm_q.got) begin
                        fsm_d.got   = 1'b0;
                        fsm_d.shreg = rd_data;
                        fsm_d.oe    = ~rd_data[7];
                        fsm_d.state = BUS_RDATA;
                    end
                end
                default: begin
                    fsm_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= BUS_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ptr    = fsm_q.ptr;
    assign sda_oe = fsm_q.oe;

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == BUS_IDLE) |-> !sda_oe);

    p_stop_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_start_rearms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (fsm_q.state == BUS_DEV));

    p_write_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == ptr_t'($past(wr_addr) + ptr_t'(1))));

endmodule

// File: rtl/sid_store.sv
module sid_store
    import sid_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_we,
    input  ptr_t  cfg_addr,
    input  byte_t cfg_wdata,
    input  logic  bus_we,
    input  ptr_t  bus_addr,
    input  byte_t bus_wdata,
    input  ptr_t  rd_addr,
    output byte_t rd_data
);

    localparam byte_t LO_INIT = image_sum(0, 62);
    localparam byte_t HI_INIT = image_sum(64, 94);

    typedef struct packed {
        byte_t [MEM_BYTES-1:0] mem;
        byte_t                 lo_sum;
        byte_t                 hi_sum;
    } store_t;

    store_t st_d, st_q;
    logic   we;
    ptr_t   waddr;
    byte_t  wdata;
    byte_t  old_byte;
    logic   in_lo, in_hi, is_ck;

    always_comb begin
        we       = cfg_we | bus_we;
        waddr    = cfg_we ? cfg_addr : bus_addr;
        wdata    = cfg_we ? cfg_wdata : bus_wdata;
        old_byte = st_q.mem[waddr];
        is_ck    = (waddr == CK_LO_POS) || (waddr == CK_HI_POS);
        in_lo    = (waddr < CK_LO_POS);
        in_hi    = (waddr >= HI_FIRST) && (waddr < CK_HI_POS);

        st_d = st_q;
        if (we && !is_ck) begin
            st_d.mem[waddr] = wdata;
            if (in_lo) begin
                st_d.lo_sum = st_q.lo_sum - old_byte + wdata;
            end
            if (in_hi) begin
                st_d.hi_sum = st_q.hi_sum - old_byte + wdata;
            end
        end

        if (rd_addr == CK_LO_POS) begin
            rd_data = st_q.lo_sum;
        end else if (rd_addr == CK_HI_POS) begin
            rd_data = st_q.hi_sum;
        end else begin
            rd_data = st_q.mem[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < MEM_BYTES; i++) begin
                st_q.mem[i] <= image_byte(i);
            end
            st_q.lo_sum <= LO_INIT;
            st_q.hi_sum <= HI_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    p_ck_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_ck) |=> ($stable(st_q.lo_sum) && $stable(st_q.hi_sum)));

    p_hi_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr < CK_LO_POS)) |=> $stable(st_q.hi_sum));

    p_reserved_no_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr > CK_HI_POS)) |=> ($stable(st_q.lo_sum) && $stable(st_q.hi_sum)));

    p_cfg_stores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !is_ck) |=> (rd_addr != $past(cfg_addr)) || (rd_data == $past(cfg_wdata)));

endmodule

// File: rtl/serial_id_mem.sv
module serial_id_mem
    import sid_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       cfg_we,
    input  logic [6:0] cfg_addr,
    input  logic [7:0] cfg_wdata
);

    logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic  bus_we;
    ptr_t  bus_ptr, bus_waddr;
    byte_t bus_wdata, rd_data;

    sid_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sid_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (bus_ptr),
        .wr_en     (bus_we),
        .wr_addr   (bus_waddr),
        .wr_data   (bus_wdata),
        .sda_oe    (sda_oe)
    );

    sid_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bus_we    (bus_we),
        .bus_addr  (bus_waddr),
        .bus_wdata (bus_wdata),
        .rd_addr   (bus_ptr),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/serial_id_mem_test.sv
`timescale 1ns/1ps
module serial_id_mem_test;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [128];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    serial_id_mem uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata)
    );

    function automatic logic [7:0] exp_byte(input int idx);
        logic [7:0] s;
        s = 8'h00;
        if (idx == 63) begin
            for (int i = 0; i < 63; i++) s = s + model[i];
            return s;
        end
        if (idx == 95) begin
            for (int i = 64; i < 95; i++) s = s + model[i];
            return s;
        end
        return model[idx];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~ack);
    endtask

    task automatic read_from(input logic [7:0] word, input int n, input string req);
        logic a;
        logic [7:0] v;
        int base;
        base = int'(word[6:0]);
        bus_start();
        send_byte(8'hA0, a);
        check({req, " dev ack"}, a, 1);
        send_byte(word, a);
        check({req, " word ack"}, a, 1);
        bus_start();
        send_byte(8'hA1, a);
        check({req, " read ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            check(req, v, exp_byte((base + k) % 128));
        end
        bus_stop();
    endtask

    task automatic bus_write3(input int start, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2);
        logic a;
        logic [7:0] d [3];
        d[0] = b0; d[1] = b1; d[2] = b2;
        bus_start();
        send_byte(8'hA0, a);
        check("R6 dev ack", a, 1);
        send_byte(8'(start), a);
        check("R6 word ack", a, 1);
        for (int k = 0; k < 3; k++) begin
            int idx;
            idx = (start + k) % 128;
            send_byte(d[k], a);
            check("R6/R10 data ack", a, 1);
            if (idx != 63 && idx != 95) model[idx] = d[k];
        end
        bus_stop();
    endtask

    task automatic cfg_write(input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx != 63 && idx != 95) model[idx] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        logic b;
        logic [7:0] v;

        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model[0] = 8'h03; model[1] = 8'h04; model[6] = 8'h08;
        model[11] = 8'h01; model[12] = 8'h0D; model[18] = 8'h64;

        repeat (5) @(negedge clk);
        check("R1 reset line released", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 sum 63 value", exp_byte(63), 8'h81);

        // R1 full image, R4 wrap past 127.
        read_from(8'h00, 130, "R1/R4 reset image");

        // R7 configuration load of a pattern; R10 attempts on 63 and 95.
        for (int i = 0; i < 128; i++) cfg_write(i, 8'((i * 29 + 7) & 8'hFF));
        read_from(8'h05, 128, "R7/R8/R9 cfg image");

        // R3 word address MSB ignored.
        read_from(8'h8A, 2, "R3 msb ignored");

        // R6/R8/R10 bus writes across window edges.
        bus_write3(62, 8'h11, 8'h22, 8'h33);
        bus_write3(94, 8'h44, 8'h55, 8'h66);
        bus_write3(127, 8'h77, 8'h88, 8'h99);
        cfg_write(63, 8'hEE);
        cfg_write(100, 8'h5A);
        read_from(8'h00, 128, "R6/R8/R9/R10 after writes");
        read_from(8'h7E, 4, "R4/R6 wrap");

        // R2 foreign device addresses.
        bus_start();
        send_byte(8'hA2, a);
        check("R2 foreign A2", a, 0);
        send_byte(8'h00, a);
        check("R2 quiet after foreign", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB1, a);
        check("R2 foreign B1", a, 0);
        bus_stop();

        // R5 NACK ends read.
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'd20, a);
        bus_start();
        send_byte(8'hA1, a);
        check("R5 read ack", a, 1);
        recv_byte(v, 1'b0);
        check("R5 byte before nack", v, exp_byte(20));
        for (int k = 0; k < 9; k++) begin
            recv_bit(b);
            check("R5 silent after nack", b, 1);
        end
        bus_stop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule